// File: doc/BRIEF.md
# Red-Object Bounding Box Video Annotator

This block sits inside a valid/ready pixel stream and rewrites each pixel on its way through. A pixel whose red channel is strong while its green and blue channels are weak is marked as a target. Target pixels leave the block as pure red, and every other pixel leaves as a grey level taken from its own colour. The stream carries no coordinates, so the block counts accepted pixels against a fixed frame width and height. It keeps the smallest and largest column and row of all target pixels seen in the frame.

When a new frame starts, the extremes gathered over the frame that just ended become the box that is drawn. Every outgoing pixel whose column equals the box's left or right column, or whose row equals its top or bottom row, is painted in a colour taken from an input port. The box that appears on screen therefore always belongs to the frame before. A frame with no target pixels draws no box in the frame that follows it.

The block holds two register stages with the recolouring logic between them. Backpressure passes straight through: a stalled consumer stalls the producer, and no pixel is dropped or repeated.

Top module: `redbox_annotator`

## Requirements
- R1: A pixel is a target when its red channel (bits 23:16) is strictly above RED_MIN (0xB0), its green channel (bits 15:8) is strictly below GREEN_MAX (0x60) and its blue channel (bits 7:0) is strictly below BLUE_MAX (0x60).
- R2: A non-target pixel outside the box leaves with all three channels equal to (R + 2G + B) / 4, with the fraction dropped.
- R3: A target pixel outside the box leaves as 0xFF0000.
- R4: A pixel whose column equals the box's left or right column, or whose row equals its top or bottom row, leaves as box_rgb. This rule takes priority over R2 and R3.
- R5: The box drawn during a frame is the minimum and maximum column and row over the target pixels of the frame before it.
- R6: If a frame has no target pixel, the frame after it shows no box.
- R7: Columns run from 0 to FRAME_W-1 over accepted transfers only. The row increments when the column wraps. A transfer accepted with in_sop set is at column 0, row 0, even if the frame before it was cut short.
- R8: A pixel accepted on an idle block appears on out_valid after two clock edges. in_sop and in_eop leave unchanged alongside their pixel, and pixels leave in the order they arrived.
- R9: While out_valid is high and out_ready is low, the output holds steady. When both stages are full and out_ready is low, in_ready is low. No pixel is lost or duplicated.
- R10: After reset, out_valid is low, in_ready is high and no box is drawn.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_data | input | 24 | Incoming pixel, R in 23:16, G in 15:8, B in 7:0 |
| in_sop | input | 1 | First pixel of a frame |
| in_eop | input | 1 | Last pixel of a frame |
| in_valid | input | 1 | Incoming pixel is valid |
| in_ready | output | 1 | Block can take an incoming pixel |
| box_rgb | input | 24 | Colour used to draw the box |
| out_data | output | 24 | Annotated pixel |
| out_sop | output | 1 | First-of-frame flag, passed through |
| out_eop | output | 1 | Last-of-frame flag, passed through |
| out_valid | output | 1 | Outgoing pixel is valid |
| out_ready | input | 1 | Consumer takes the outgoing pixel |

## Verification
A wrong column or row count does not fail at once. It shows up one frame later, as box lines drawn in the wrong column or row, so the bench always checks the frame that follows the damaged one. The same applies to a wrong extreme or a lost presence flag: the damage appears as a missing or misplaced box only in the next frame. Problems in the stages or the ready path show up within a cycle or two, as pixels that are lost, repeated or out of order, or as output that changes while the consumer is stalled.

// File: rtl/redbox_pkg.sv
`timescale 1ns/1ps
package redbox_pkg;

    typedef struct packed {
        logic [7:0] r;
        logic [7:0] g;
        logic [7:0] b;
    } rgb_t;

    typedef struct packed {
        logic sop;
        logic eop;
        rgb_t px;
    } beat_t;

    localparam int BEAT_W = $bits(beat_t);

    typedef enum logic [1:0] {
        PX_GREY  = 2'd0,
        PX_RED   = 2'd1,
        PX_FRAME = 2'd2
    } px_kind_e;

    localparam rgb_t RED_MARK = '{r: 8'hFF, g: 8'h00, b: 8'h00};

    function automatic rgb_t to_grey(input rgb_t p);
        logic [9:0] s;
        s = {2'b00, p.r} + {1'b0, p.g, 1'b0} + {2'b00, p.b};
        return '{r: s[9:2], g: s[9:2], b: s[9:2]};
    endfunction

    function automatic logic is_target(input rgb_t p, input logic [7:0] rmin,
                                       input logic [7:0] gmax, input logic [7:0] bmax);
        return (p.r > rmin) && (p.g < gmax) && (p.b < bmax);
    endfunction

endpackage

// File: rtl/rb_stage.sv
`timescale 1ns/1ps
module rb_stage #(
    parameter int DW = 26
) (
    input  logic          clk,
    input  logic          rst,
    input  logic [DW-1:0] up_data,
    input  logic          up_valid,
    output logic          up_ready,
    output logic [DW-1:0] dn_data,
    output logic          dn_valid,
    input  logic          dn_ready
);
    // Register is free when empty or being drained this cycle.
    assign up_ready = !dn_valid || dn_ready;

    always_ff @(posedge clk) begin
        if (rst) begin
            dn_valid <= 1'b0;
            dn_data  <= '0;
        end else if (up_ready) begin
            dn_valid <= up_valid;
            if (up_valid) dn_data <= up_data;
        end
    end
endmodule

// File: rtl/rb_coord.sv
`timescale 1ns/1ps
module rb_coord #(
    parameter int WIDTH  = 640,
    parameter int HEIGHT = 480,
    localparam int XW = $clog2(WIDTH),
    localparam int YW = $clog2(HEIGHT)
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          fire,
    input  logic          sop,
    output logic [XW-1:0] cur_x,
    output logic [YW-1:0] cur_y
);
    localparam logic [XW-1:0] X_LAST = XW'(WIDTH - 1);
    localparam logic [YW-1:0] Y_LAST = YW'(HEIGHT - 1);

    logic [XW-1:0] x_cnt;
    logic [YW-1:0] y_cnt;

    // A start-of-frame pixel is placed at the origin regardless of the count.
    assign cur_x = sop ? '0 : x_cnt;
    assign cur_y = sop ? '0 : y_cnt;

    always_ff @(posedge clk) begin
        if (rst) begin
            x_cnt <= '0;
            y_cnt <= '0;
        end else if (fire) begin
            if (cur_x == X_LAST) begin
                x_cnt <= '0;
                y_cnt <= (cur_y == Y_LAST) ? '0 : cur_y + YW'(1);
            end else begin
                x_cnt <= cur_x + XW'(1);
                y_cnt <= cur_y;
            end
        end
    end
endmodule

// File: rtl/rb_extent.sv
`timescale 1ns/1ps
module rb_extent #(
    parameter int LIMIT = 640,
    localparam int CW = $clog2(LIMIT)
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          fire,
    input  logic          sop,
    input  logic          hit,
    input  logic [CW-1:0] pos,
    output logic [CW-1:0] shown_lo,
    output logic [CW-1:0] shown_hi
);
    localparam logic [CW-1:0] TOP = CW'(LIMIT - 1);

    logic [CW-1:0] run_lo, run_hi, keep_lo, keep_hi;
    logic [CW-1:0] base_lo, base_hi;

    // At frame start the running extremes restart before this pixel is folded in.
    assign base_lo = sop ? TOP : run_lo;
    assign base_hi = sop ? '0  : run_hi;

    // The first pixel of a frame already sees the extremes it is about to latch.
    assign shown_lo = sop ? run_lo : keep_lo;
    assign shown_hi = sop ? run_hi : keep_hi;

    always_ff @(posedge clk) begin
        if (rst) begin
            run_lo  <= TOP;
            run_hi  <= '0;
            keep_lo <= TOP;
            keep_hi <= '0;
        end else if (fire) begin
            run_lo <= (hit && pos < base_lo) ? pos : base_lo;
            run_hi <= (hit && pos > base_hi) ? pos : base_hi;
            if (sop) begin
                keep_lo <= run_lo;
                keep_hi <= run_hi;
            end
        end
    end
endmodule

// File: rtl/rb_pixel_map.sv
`timescale 1ns/1ps
module rb_pixel_map
    import redbox_pkg::*;
#(
    parameter int         XW        = 10,
    parameter int         YW        = 9,
    parameter logic [7:0] RED_MIN   = 8'hB0,
    parameter logic [7:0] GREEN_MAX = 8'h60,
    parameter logic [7:0] BLUE_MAX  = 8'h60
) (
    input  rgb_t          px_in,
    input  logic [XW-1:0] x,
    input  logic [YW-1:0] y,
    input  logic [XW-1:0] left,
    input  logic [XW-1:0] right,
    input  logic [YW-1:0] top,
    input  logic [YW-1:0] bottom,
    input  logic          show,
    input  rgb_t          frame_rgb,
    output rgb_t          px_out,
    output logic          hit
);
    px_kind_e kind;
    logic     on_line;

    always_comb begin
        hit     = is_target(px_in, RED_MIN, GREEN_MAX, BLUE_MAX);
        on_line = show && ((x == left) || (x == right) || (y == top) || (y == bottom));
        if (on_line)  kind = PX_FRAME;
        else if (hit) kind = PX_RED;
        else          kind = PX_GREY;
        case (kind)
            PX_FRAME: px_out = frame_rgb;
            PX_RED:   px_out = RED_MARK;
            default:  px_out = to_grey(px_in);
        endcase
    end
endmodule

// File: rtl/redbox_annotator.sv
`timescale 1ns/1ps
module redbox_annotator
    import redbox_pkg::*;
#(
    parameter int         FRAME_W   = 640,
    parameter int         FRAME_H   = 480,
    parameter logic [7:0] RED_MIN   = 8'hB0,
    parameter logic [7:0] GREEN_MAX = 8'h60,
    parameter logic [7:0] BLUE_MAX  = 8'h60,
    localparam int XW = $clog2(FRAME_W),
    localparam int YW = $clog2(FRAME_H)
) (
    input  logic        clk,
    input  logic        rst,
    input  logic [23:0] in_data,
    input  logic        in_sop,
    input  logic        in_eop,
    input  logic        in_valid,
    output logic        in_ready,
    input  logic [23:0] box_rgb,
    output logic [23:0] out_data,
    output logic        out_sop,
    output logic        out_eop,
    output logic        out_valid,
    input  logic        out_ready
);
    beat_t         up_beat, a_beat, p_beat, b_beat;
    logic          a_valid, b_take, fire;
    logic [XW-1:0] cur_x, box_l, box_r;
    logic [YW-1:0] cur_y, box_t, box_b;
    logic          hit, run_seen, keep_seen, base_seen, show;
    rgb_t          mapped;

    assign up_beat = '{sop: in_sop, eop: in_eop, px: rgb_t'(in_data)};

    rb_stage #(.DW(BEAT_W)) u_stage_in (
        .clk      (clk),
        .rst      (rst),
        .up_data  (up_beat),
        .up_valid (in_valid),
        .up_ready (in_ready),
        .dn_data  (a_beat),
        .dn_valid (a_valid),
        .dn_ready (b_take)
    );

    // A pixel is consumed from the first stage when the second stage takes it.
    assign fire = a_valid && b_take;

    rb_coord #(.WIDTH(FRAME_W), .HEIGHT(FRAME_H)) u_coord (
        .clk   (clk),
        .rst   (rst),
        .fire  (fire),
        .sop   (a_beat.sop),
        .cur_x (cur_x),
        .cur_y (cur_y)
    );

    rb_extent #(.LIMIT(FRAME_W)) u_ext_x (
        .clk      (clk),
        .rst      (rst),
        .fire     (fire),
        .sop      (a_beat.sop),
        .hit      (hit),
        .pos      (cur_x),
        .shown_lo (box_l),
        .shown_hi (box_r)
    );

    rb_extent #(.LIMIT(FRAME_H)) u_ext_y (
        .clk      (clk),
        .rst      (rst),
        .fire     (fire),
        .sop      (a_beat.sop),
        .hit      (hit),
        .pos      (cur_y),
        .shown_lo (box_t),
        .shown_hi (box_b)
    );

    // Presence flag: whether any target pixel fed the extremes.
    assign base_seen = a_beat.sop ? 1'b0 : run_seen;
    assign show      = a_beat.sop ? run_seen : keep_seen;

    always_ff @(posedge clk) begin
        if (rst) begin
            run_seen  <= 1'b0;
            keep_seen <= 1'b0;
        end else if (fire) begin
            run_seen <= base_seen || hit;
            if (a_beat.sop) keep_seen <= run_seen;
        end
    end

    rb_pixel_map #(
        .XW(XW), .YW(YW),
        .RED_MIN(RED_MIN), .GREEN_MAX(GREEN_MAX), .BLUE_MAX(BLUE_MAX)
    ) u_map (
        .px_in     (a_beat.px),
        .x         (cur_x),
        .y         (cur_y),
        .left      (box_l),
        .right     (box_r),
        .top       (box_t),
        .bottom    (box_b),
        .show      (show),
        .frame_rgb (rgb_t'(box_rgb)),
        .px_out    (mapped),
        .hit       (hit)
    );

    assign p_beat = '{sop: a_beat.sop, eop: a_beat.eop, px: mapped};

    rb_stage #(.DW(BEAT_W)) u_stage_out (
        .clk      (clk),
        .rst      (rst),
        .up_data  (p_beat),
        .up_valid (a_valid),
        .up_ready (b_take),
        .dn_data  (b_beat),
        .dn_valid (out_valid),
        .dn_ready (out_ready)
    );

    assign out_data = b_beat.px;
    assign out_sop  = b_beat.sop;
    assign out_eop  = b_beat.eop;
endmodule

// File: rtl/redbox_annotator_chk.sv
`timescale 1ns/1ps
module redbox_annotator_chk (
    input logic        clk,
    input logic        rst,
    input logic        in_ready,
    input logic        a_valid,
    input logic [23:0] box_rgb,
    input logic [23:0] out_data,
    input logic        out_sop,
    input logic        out_eop,
    input logic        out_valid,
    input logic        out_ready
);
    // R9: a stalled output keeps its pixel and flags.
    assert_hold_R9: assert property (@(posedge clk) disable iff (rst)
        (out_valid && !out_ready) |=> (out_valid && $stable(out_data) && $stable(out_sop) && $stable(out_eop)));

    // R9: both stages full and consumer stalled means producer is stalled.
    assert_stall_R9: assert property (@(posedge clk) disable iff (rst)
        (out_valid && !out_ready && a_valid) |-> !in_ready);

    // R2 R3 R4: every output pixel is grey, the red mark or the box colour.
    assert_palette_R4: assert property (@(posedge clk) disable iff (rst)
        out_valid |-> ((out_data[23:16] == out_data[15:8] && out_data[15:8] == out_data[7:0])
                       || out_data == 24'hFF0000 || out_data == $past(box_rgb)));

    // R10: reset empties the output and opens the input.
    assert_reset_R10: assert property (@(posedge clk)
        rst |=> (!out_valid && in_ready));

    // R8: an output pixel only appears after something was held in the first stage.
    assert_order_R8: assert property (@(posedge clk) disable iff (rst)
        ($rose(out_valid)) |-> $past(a_valid));
endmodule

bind redbox_annotator redbox_annotator_chk u_chk (
    .clk       (clk),
    .rst       (rst),
    .in_ready  (in_ready),
    .a_valid   (a_valid),
    .box_rgb   (box_rgb),
    .out_data  (out_data),
    .out_sop   (out_sop),
    .out_eop   (out_eop),
    .out_valid (out_valid),
    .out_ready (out_ready)
);

// File: tb/redbox_annotator_bench.sv
`timescale 1ns/1ps
module redbox_annotator_bench;
    localparam int W = 8;
    localparam int H = 4;
    localparam int NPIX = W * H;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [23:0] in_data = '0;
    logic        in_sop = 1'b0, in_eop = 1'b0, in_valid = 1'b0;
    logic        in_ready;
    logic [23:0] box_rgb = 24'h00FF00;
    logic [23:0] out_data;
    logic        out_sop, out_eop, out_valid;
    logic        out_ready = 1'b1;

    int checks = 0, failures = 0, cyc = 0, mcyc = 0, rdy_mode = 0;
    logic [25:0] exp_q[$];
    string       tag_q[$];

    // {input pixel, expected output} for a first frame with no box drawn.
    localparam logic [47:0] VEC [8] = '{
        {24'hFF0000, 24'hFF0000},   // R1 target
        {24'hB00000, 24'h2C2C2C},   // R1 red at threshold is not a target, R2
        {24'hB10000, 24'hFF0000},   // R1 just above threshold
        {24'hFF6000, 24'h6F6F6F},   // R1 green at threshold, R2
        {24'hFF5F5F, 24'hFF0000},   // R1 green and blue just below
        {24'hFFFFFF, 24'hFFFFFF},   // R2 white
        {24'h102030, 24'h202020},   // R2 weighted mix
        {24'hC8405F, 24'hFF0000}    // R3
    };

    redbox_annotator #(.FRAME_W(W), .FRAME_H(H)) u_redbox_annotator (
        .clk(clk), .rst(rst), .in_data(in_data), .in_sop(in_sop), .in_eop(in_eop),
        .in_valid(in_valid), .in_ready(in_ready), .box_rgb(box_rgb),
        .out_data(out_data), .out_sop(out_sop), .out_eop(out_eop),
        .out_valid(out_valid), .out_ready(out_ready)
    );

    always #10 clk = ~clk;

    task automatic check(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] expv);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=%h expected=%h", tag, act, expv);
        end
    endtask

    always @(posedge clk) begin
        cyc++;
        if (cyc > 100000) begin
            failures++;
            $display("FAIL watchdog actual=%0d expected=done", cyc);
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    // Consumer: sets out_ready for the coming edge, then checks the beat it takes.
    always @(negedge clk) begin
        mcyc++;
        case (rdy_mode)
            0:       out_ready = 1'b1;
            1:       out_ready = (mcyc % 3) != 0;
            default: out_ready = 1'b0;
        endcase
        #1;
        if (!rst && out_valid && out_ready) begin
            if (exp_q.size() == 0) begin
                check(1'b0, "R9 unexpected beat", {6'd0, out_sop, out_eop, out_data}, 32'd0);
            end else begin
                logic [25:0] e;
                string t;
                e = exp_q.pop_front();
                t = tag_q.pop_front();
                check({out_sop, out_eop, out_data} == e, t, {6'd0, out_sop, out_eop, out_data}, {6'd0, e});
            end
        end
    end

    task automatic send(input logic [23:0] d, input logic s, input logic e, input int gap,
                        input logic [23:0] ex, input string tag);
        repeat (gap) @(negedge clk);
        @(negedge clk);
        in_data = d; in_sop = s; in_eop = e; in_valid = 1'b1;
        exp_q.push_back({s, e, ex});
        tag_q.push_back(tag);
        #2;
        while (!in_ready) begin
            @(negedge clk);
            #2;
        end
        @(posedge clk);
        #1 in_valid = 1'b0;
    endtask

    task automatic drain();
        while (exp_q.size() != 0) @(negedge clk);
        repeat (2) @(negedge clk);
    endtask

    function automatic logic [23:0] frame_pix(input int f, input int idx);
        case (f)
            1: return (idx < 8) ? VEC[idx][47:24] : ((idx == 19) ? 24'hFF0000 : 24'h000000);
            5: return (idx == 1) ? 24'hFF0000 : 24'h808080;
            default: return 24'h808080;
        endcase
    endfunction

    function automatic logic [23:0] frame_exp(input int f, input int idx);
        int x, y;
        x = idx % W;
        y = idx / W;
        case (f)
            1: return (idx < 8) ? VEC[idx][23:0] : ((idx == 19) ? 24'hFF0000 : 24'h000000);
            2: return (x == 0 || x == 7 || y == 0 || y == 2) ? box_rgb : 24'h808080;
            5: return (idx == 1) ? 24'hFF0000 : 24'h808080;
            6: return (x == 1 || y == 0) ? box_rgb : 24'h808080;
            default: return 24'h808080;
        endcase
    endfunction

    task automatic send_frame(input int f, input int n, input int gap, input string tag);
        for (int i = 0; i < n; i++)
            send(frame_pix(f, i), i == 0, (i == n - 1) && (n == NPIX), gap, frame_exp(f, i), tag);
    endtask

    initial begin
        repeat (4) @(negedge clk);
        rst = 1'b0;
        #3;
        check(out_valid == 1'b0, "R10 out_valid after reset", {31'd0, out_valid}, 32'd0);
        check(in_ready == 1'b1, "R10 in_ready after reset", {31'd0, in_ready}, 32'd1);

        // R8: latency of a lone pixel (a one-pixel frame with no target).
        send(24'h000000, 1'b1, 1'b1, 0, 24'h000000, "R8 lone pixel");
        @(negedge clk); #3;
        check(out_valid == 1'b0, "R8 not yet after one edge", {31'd0, out_valid}, 32'd0);
        @(negedge clk); #3;
        check(out_valid == 1'b1, "R8 valid after two edges", {31'd0, out_valid}, 32'd1);
        drain();

        // R1 R2 R3 table walk with gaps between pixels (R7: gaps do not advance).
        send_frame(1, NPIX, 1, "R1 R2 R3 table frame, R10 no box yet");
        drain();

        // R4 R5: box from frame 1 (columns 0,7 rows 0,2) under irregular out_ready.
        rdy_mode = 1;
        send_frame(2, NPIX, 0, "R4 R5 box of previous frame");
        drain();
        rdy_mode = 0;

        // R6: frame 2 held no target, so frame 3 shows no box.
        send_frame(3, NPIX, 0, "R6 no box after empty frame");
        drain();

        // R7: a cut-short frame, then a new start-of-frame restarts counting.
        send_frame(4, 3, 0, "R7 short frame");
        send_frame(5, NPIX, 2, "R7 restarted frame");
        drain();
        box_rgb = 24'h0000FF;
        send_frame(6, NPIX, 0, "R7 box at column 1 row 0");
        drain();

        // R9: stall the consumer and fill both stages.
        rdy_mode = 2;
        repeat (2) @(negedge clk);
        in_data = 24'hFF0000; in_sop = 1'b1; in_eop = 1'b0; in_valid = 1'b1;
        exp_q.push_back({1'b1, 1'b0, 24'hFF0000}); tag_q.push_back("R9 first held beat");
        @(posedge clk); #1;
        in_data = 24'h808080; in_sop = 1'b0;
        exp_q.push_back({1'b0, 1'b0, 24'h808080}); tag_q.push_back("R9 second held beat");
        @(posedge clk); #1;
        in_valid = 1'b0;
        @(negedge clk); #2;
        check(out_valid == 1'b1, "R9 output valid while stalled", {31'd0, out_valid}, 32'd1);
        check(in_ready == 1'b0, "R9 in_ready low when full", {31'd0, in_ready}, 32'd0);
        check(out_data == 24'hFF0000, "R9 head pixel", {8'd0, out_data}, {8'd0, 24'hFF0000});
        repeat (3) @(negedge clk);
        #2;
        check(out_valid == 1'b1 && out_data == 24'hFF0000, "R9 held across stall",
              {7'd0, out_valid, out_data}, {7'd0, 1'b1, 24'hFF0000});
        rdy_mode = 0;
        drain();
        check(exp_q.size() == 0, "R9 every beat delivered", exp_q.size(), 32'd0);

        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule